// File: doc/BRIEF.md
# Unaligned Access Bus Splitter

This block takes one single-register load or store and turns it into one or two naturally aligned transfers on a 32-bit bus. A request gives a byte address, an access size of a byte, a halfword or a word, a store flag and right-justified store data. The block issues the word-aligned address strobes with big-endian byte enables and lane-placed store data. It counts the bus terminations in order, and for a load it assembles the returned lanes into a right-justified, zero-filled result.

An access that crosses a word boundary is split in two. The first transfer covers the bytes from the offset up to the end of the word. The second, at the next word address, covers the rest. The second strobe goes out on the clock after the first and does not wait for the first termination. Each strobe carries its own speculation tag, taken from the ordering logic when that strobe launches, so the two halves of one access can be tagged differently. An abort input drops whatever is left of the current request.

Top module: `ua_split`

## Requirements
- R1: Every strobe's `bus_addr` has its two low bits zero. The first strobe carries the request address with those bits cleared, and a second strobe carries that address plus 4.
- R2: Let n be the byte count: 1 for `req_size`=0, 2 for 1, and 4 for 2 or 3. With offset o = `req_addr[1:0]`, the request takes one strobe when o+n ≤ 4 and two strobes otherwise. A byte access therefore always takes one.
- R3: `bus_be[3]` selects lane 0 (`bus_wdata`/`bus_rdata` bits 31:24) and `bus_be[0]` selects lane 3 (bits 7:0). The first strobe enables lanes o through min(o+n,4)-1, and a second strobe enables lanes 0 through o+n-5.
- R4: On a store, the most significant of the n low bytes of `req_wdata` goes to the lowest address, and each byte sits in the lane of its address. Bytes of `req_wdata` above the n low ones are ignored, and disabled lanes carry zero.
- R5: A second strobe appears on the clock right after the first, whether or not the first has terminated. No more than two transfers of one request are ever outstanding, and terminations are matched to strobes in issue order.
- R6: Each strobe's `bus_spec` equals `spec_tag` as sampled at the clock edge that launches that strobe.
- R7: For a load, `res_data` holds the n addressed bytes in big-endian order, right-justified and zero-extended. `res_valid` pulses for one clock, starting the clock after the last termination.
- R8: A store never raises `res_valid`.
- R9: `req_ready` is high out of reset and while idle. It is low from the accepting edge until the last termination, high again the clock after, and no strobe is shown while it is high.
- R10: `abort` while busy returns the block to idle on the next clock: `req_ready` high, no further strobes, and no result for that request. A termination while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Drop the remaining transfers of the current request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_store | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Right-justified store data |
| spec_tag | input | 1 | Speculation tag from the ordering logic |
| bus_valid | output | 1 | Address strobe, one clock per transfer |
| bus_addr | output | 32 | Word-aligned transfer address |
| bus_be | output | 4 | Byte enables, bit 3 = lane 0 |
| bus_write | output | 1 | Transfer direction, 1 = write |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_spec | output | 1 | Speculation tag of this transfer |
| bus_ack | input | 1 | Transfer termination, in issue order |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| res_valid | output | 1 | Load result pulse |
| res_data | output | 32 | Right-justified, zero-extended load result |

## Verification
A wrong strobe count or a lost termination count shows first as a strobe that was not expected, or one that is missing, on the clock after acceptance. If that is missed, `req_ready` stays low past the last termination, or the result pulse comes one termination too early. A wrong shift amount or a stale high-half register shows only in the value of `res_data` on the single clock of the result pulse. So every load result is compared byte for byte, at every offset and size. Abort faults show up one clock after `abort`, either as a leftover second strobe or as a result that should not appear.

// File: rtl/ua_split_pkg.sv
package ua_split_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } ua_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SECOND = 2'd1,
    ST_WAIT   = 2'd2
  } ua_state_e;

endpackage

// File: rtl/ua_split_plan.sv
// Combinational cut planner: from address, size and store data it derives
// how many aligned transfers are needed, their addresses, enables and lane data.
module ua_split_plan #(
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic [AW-1:0]                     addr,
  input  logic [1:0]                        size,
  input  logic [DATA_W-1:0]                 wdata,
  output logic                              two,
  output logic [AW-1:0]                     addr0,
  output logic [AW-1:0]                     addr1,
  output logic [DATA_W/8-1:0]               be0,
  output logic [DATA_W/8-1:0]               be1,
  output logic [DATA_W-1:0]                 wd0,
  output logic [DATA_W-1:0]                 wd1,
  output logic [$clog2(DATA_W/8)+1:0]       sh,
  output logic [$clog2(DATA_W/8)+1:0]       nb
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int CNT_W = OFS_W + 2;

  logic [OFS_W-1:0]    ofs;
  logic [CNT_W-1:0]    endp;
  logic [DATA_W-1:0]   dmask;
  logic [2*DATA_W-1:0] img;
  logic [2*LANES-1:0]  bmask;

  always_comb begin
    ofs = addr[OFS_W-1:0];
    if (int'(size) >= OFS_W) nb = CNT_W'(LANES);
    else                     nb = CNT_W'(1) << size;
    endp = CNT_W'(ofs) + nb;
    two  = endp > CNT_W'(LANES);
    sh   = CNT_W'(2 * LANES) - endp;
  end

  // byte-granular masks, one slice per lane / per position of the two-word window
  for (genvar i = 0; i < LANES; i++) begin : g_dmask
    assign dmask[8*i +: 8] = (CNT_W'(i) < nb) ? 8'hFF : 8'h00;
  end

  for (genvar p = 0; p < 2*LANES; p++) begin : g_bmask
    assign bmask[2*LANES-1-p] = (CNT_W'(p) >= CNT_W'(ofs)) && (CNT_W'(p) < endp);
  end

  always_comb begin
    img   = {{DATA_W{1'b0}}, wdata & dmask} << {sh, 3'b000};
    wd0   = img[2*DATA_W-1:DATA_W];
    wd1   = img[DATA_W-1:0];
    be0   = bmask[2*LANES-1:LANES];
    be1   = bmask[LANES-1:0];
    addr0 = {addr[AW-1:OFS_W], {OFS_W{1'b0}}};
    addr1 = addr0 + AW'(LANES);
  end

endmodule

// File: rtl/ua_split_seq.sv
// Issue sequencer: launches the aligned strobes back to back, tags each one,
// counts terminations in order and handles abort.
module ua_split_seq
  import ua_split_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  abort,
  input  logic                  req_valid,
  input  logic [1:0]            req_size,
  input  logic                  req_store,
  input  logic                  spec_tag,
  input  logic                  p_two,
  input  logic [AW-1:0]         p_addr0,
  input  logic [AW-1:0]         p_addr1,
  input  logic [DATA_W/8-1:0]   p_be0,
  input  logic [DATA_W/8-1:0]   p_be1,
  input  logic [DATA_W-1:0]     p_wd0,
  input  logic [DATA_W-1:0]     p_wd1,
  input  logic                  bus_ack,
  output logic                  req_ready,
  output logic                  accept,
  output logic                  bus_valid,
  output logic [AW-1:0]         bus_addr,
  output logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_write,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_spec,
  output logic                  ack_fire,
  output logic                  ack_last,
  output logic                  ack_idx
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  ua_state_e           state;
  logic                two_r;
  logic                ack_cnt;
  logic [AW-1:0]       addr1_r;
  logic [LANES-1:0]    be1_r;
  logic [DATA_W-1:0]   wd1_r;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ack_fire  = bus_ack && (state != ST_IDLE) && !abort;
  assign ack_last  = ack_fire && (ack_cnt == two_r);
  assign ack_idx   = ack_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      two_r     <= 1'b0;
      ack_cnt   <= 1'b0;
      addr1_r   <= '0;
      be1_r     <= '0;
      wd1_r     <= '0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      bus_spec  <= 1'b0;
    end else begin
      bus_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            bus_valid <= 1'b1;
            bus_addr  <= p_addr0;
            bus_be    <= p_be0;
            bus_wdata <= p_wd0;
            bus_write <= req_store;
            bus_spec  <= spec_tag;
            two_r     <= p_two;
            addr1_r   <= p_addr1;
            be1_r     <= p_be1;
            wd1_r     <= p_wd1;
            ack_cnt   <= 1'b0;
            state     <= p_two ? ST_SECOND : ST_WAIT;
          end
        end
        ST_SECOND: begin
          if (abort) begin
            state <= ST_IDLE;
          end else begin
            bus_valid <= 1'b1;
            bus_addr  <= addr1_r;
            bus_be    <= be1_r;
            bus_wdata <= wd1_r;
            bus_spec  <= spec_tag;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (abort) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (ack_fire) begin
        if (ack_last) state   <= ST_IDLE;
        else          ack_cnt <= 1'b1;
      end
    end
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_addr[OFS_W-1:0] == '0)); // R1

  AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && req_size == SZ_BYTE) |=> (state != ST_SECOND)); // R2

  AST_SECOND_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SECOND && !abort) |=> bus_valid); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && ack_cnt) |-> two_r); // R5

  AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_valid); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (abort && !req_ready) |=> (req_ready && !bus_valid)); // R10

endmodule

// File: rtl/ua_split_gather.sv
// Load gatherer: keeps the high half of a split load and shifts the
// two-word window down to a right-justified, zero-filled result.
module ua_split_gather #(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  logic                          req_store,
  input  logic [$clog2(DATA_W/8)+1:0]   p_sh,
  input  logic [$clog2(DATA_W/8)+1:0]   p_nb,
  input  logic                          ack_fire,
  input  logic                          ack_last,
  input  logic                          ack_idx,
  input  logic [DATA_W-1:0]             bus_rdata,
  output logic                          res_valid,
  output logic [DATA_W-1:0]             res_data
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES) + 2;

  logic                load_r;
  logic [CNT_W-1:0]    sh_r;
  logic [CNT_W-1:0]    nb_r;
  logic [DATA_W-1:0]   hi_r;
  logic [2*DATA_W-1:0] img;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   rmask;

  for (genvar i = 0; i < LANES; i++) begin : g_rmask
    assign rmask[8*i +: 8] = (CNT_W'(i) < nb_r) ? 8'hFF : 8'h00;
  end

  always_comb begin
    img     = {(ack_idx ? hi_r : bus_rdata), bus_rdata};
    shifted = img >> {sh_r, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_r    <= 1'b0;
      sh_r      <= '0;
      nb_r      <= '0;
      hi_r      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        load_r <= !req_store;
        sh_r   <= p_sh;
        nb_r   <= p_nb;
      end
      if (ack_fire && !ack_idx) hi_r <= bus_rdata;
      if (ack_last && load_r) begin
        res_valid <= 1'b1;
        res_data  <= shifted[DATA_W-1:0] & rmask;
      end
    end
  end

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R7

  AST_RES_AFTER_TERM: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(ack_last)); // R7

endmodule

// File: rtl/ua_split.sv
module ua_split #(
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  abort,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_store,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  spec_tag,
  output logic                  bus_valid,
  output logic [AW-1:0]         bus_addr,
  output logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_write,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_spec,
  input  logic                  bus_ack,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  res_valid,
  output logic [DATA_W-1:0]     res_data
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES) + 2;

  logic               p_two;
  logic [AW-1:0]      p_addr0, p_addr1;
  logic [LANES-1:0]   p_be0, p_be1;
  logic [DATA_W-1:0]  p_wd0, p_wd1;
  logic [CNT_W-1:0]   p_sh, p_nb;
  logic               accept, ack_fire, ack_last, ack_idx;

  ua_split_plan #(.AW(AW), .DATA_W(DATA_W)) u_plan (
    .addr  (req_addr),
    .size  (req_size),
    .wdata (req_wdata),
    .two   (p_two),
    .addr0 (p_addr0),
    .addr1 (p_addr1),
    .be0   (p_be0),
    .be1   (p_be1),
    .wd0   (p_wd0),
    .wd1   (p_wd1),
    .sh    (p_sh),
    .nb    (p_nb)
  );

  ua_split_seq #(.AW(AW), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_store (req_store),
    .spec_tag  (spec_tag),
    .p_two     (p_two),
    .p_addr0   (p_addr0),
    .p_addr1   (p_addr1),
    .p_be0     (p_be0),
    .p_be1     (p_be1),
    .p_wd0     (p_wd0),
    .p_wd1     (p_wd1),
    .bus_ack   (bus_ack),
    .req_ready (req_ready),
    .accept    (accept),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .bus_spec  (bus_spec),
    .ack_fire  (ack_fire),
    .ack_last  (ack_last),
    .ack_idx   (ack_idx)
  );

  ua_split_gather #(.DATA_W(DATA_W)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_store (req_store),
    .p_sh      (p_sh),
    .p_nb      (p_nb),
    .ack_fire  (ack_fire),
    .ack_last  (ack_last),
    .ack_idx   (ack_idx),
    .bus_rdata (bus_rdata),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

endmodule

// File: tb/ua_split_tb.sv
`timescale 1ns/1ps
module ua_split_tb;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        wr;
    logic        spec;
  } bus_item_t;

  logic        clk = 1'b0;
  logic        rst, abort, req_valid, req_store, spec_tag, bus_ack;
  logic        req_ready, bus_valid, bus_write, bus_spec, res_valid;
  logic [31:0] req_addr, req_wdata, bus_addr, bus_wdata, bus_rdata, res_data;
  logic [1:0]  req_size;
  logic [3:0]  bus_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bus_item_t   bus_q[$];
  logic [31:0] res_q[$];

  always #4 clk = ~clk;

  ua_split u_dut (
    .clk(clk), .rst(rst), .abort(abort), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_store(req_store), .req_wdata(req_wdata),
    .spec_tag(spec_tag), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_spec(bus_spec), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as strobes and results appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (bus_valid) begin
        if (bus_q.size() == 0) begin
          chk(1'b0, "R5 unexpected strobe", bus_addr, 32'h0);
        end else begin
          bus_item_t it;
          it = bus_q.pop_front();
          chk(bus_addr == it.addr, "R1 address", bus_addr, it.addr);
          chk(bus_be == it.be, "R3 byte enables", {28'h0, bus_be}, {28'h0, it.be});
          chk(bus_spec == it.spec, "R6 spec tag", {31'h0, bus_spec}, {31'h0, it.spec});
          chk(bus_write == it.wr, "R4 direction", {31'h0, bus_write}, {31'h0, it.wr});
          if (it.wr) chk(bus_wdata == it.wd, "R4 store lanes", bus_wdata, it.wd);
        end
      end
      if (res_valid) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", res_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = res_q.pop_front();
          chk(res_data == e, "R7 load result", res_data, e);
        end
      end
    end
  end

  // driver: builds expectations from the requirement rules, then plays request and bus
  task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic st,
                        input logic [31:0] wd, input logic [31:0] r0, input logic [31:0] r1,
                        input logic s0, input logic s1, input int dly, input bit abrt);
    int n, o, nc;
    logic [3:0]  ebe[2];
    logic [31:0] ewd[2];
    logic [31:0] rr[2];
    logic [31:0] er;
    bus_item_t   it;
    n  = (sz >= 2) ? 4 : (1 << sz);
    o  = int'(a[1:0]);
    nc = (o + n > 4) ? 2 : 1;
    rr[0] = r0; rr[1] = r1;
    ebe[0] = 4'h0; ebe[1] = 4'h0; ewd[0] = 32'h0; ewd[1] = 32'h0; er = 32'h0;
    for (int k = 0; k < n; k++) begin
      int p, c, ln;
      p = o + k; c = p / 4; ln = p % 4;
      ebe[c][3-ln] = 1'b1;
      ewd[c][31-8*ln -: 8] = wd[8*(n-1-k) +: 8];
      er = (er << 8) | {24'h0, rr[c][31-8*ln -: 8]};
    end
    for (int c = 0; c < nc; c++) begin
      if (!(abrt && c == 1)) begin
        it.addr = {a[31:2], 2'b00} + 32'(4*c);
        it.be   = ebe[c];
        it.wd   = ewd[c];
        it.wr   = st;
        it.spec = (c == 0) ? s0 : s1;
        bus_q.push_back(it);
      end
    end
    if (!st && !abrt) res_q.push_back(er);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_store = st; req_wdata = wd; spec_tag = s0;
    @(negedge clk);
    req_valid = 1'b0; spec_tag = s1;
    chk(req_ready == 1'b0, "R9 busy after accept", {31'h0, req_ready}, 32'h0);
    if (abrt) begin
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(req_ready == 1'b1, "R10 idle after abort", {31'h0, req_ready}, 32'h1);
      chk(bus_valid == 1'b0, "R10 no strobe after abort", {31'h0, bus_valid}, 32'h0);
      return;
    end
    for (int c = 0; c < nc; c++) begin
      repeat (dly) @(negedge clk);
      bus_ack = 1'b1; bus_rdata = rr[c];
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = 32'hA5C3_0F96;
    end
    chk(req_ready == 1'b1, "R9 ready after last termination", {31'h0, req_ready}, 32'h1);
    if (st) chk(res_valid == 1'b0, "R8 no result on store", {31'h0, res_valid}, 32'h0);
    else    chk(res_valid == 1'b1, "R7 result timing", {31'h0, res_valid}, 32'h1);
  endtask

  initial begin
    rst = 1'b1; abort = 1'b0; req_valid = 1'b0; req_store = 1'b0; spec_tag = 1'b0;
    bus_ack = 1'b0; req_addr = '0; req_wdata = '0; req_size = '0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", {31'h0, req_ready}, 32'h1);
    chk(bus_valid == 1'b0, "R9 reset no strobe", {31'h0, bus_valid}, 32'h0);
    chk(res_valid == 1'b0, "R7 reset no result", {31'h0, res_valid}, 32'h0);

    // R2 byte loads at every offset, one transfer each
    for (int o = 0; o < 4; o++)
      do_req(32'h1000_0100 + 32'(o), 2'd0, 1'b0, 32'h0, 32'h1122_3344, 32'h5566_7788, 1'b1, 1'b0, o % 2, 1'b0);
    // R2 R3 halfword loads, offset 3 splits
    for (int o = 0; o < 4; o++)
      do_req(32'h2000_0200 + 32'(o), 2'd1, 1'b0, 32'h0, 32'h8899_AABB, 32'hCCDD_EEFF, 1'b0, 1'b1, 0, 1'b0);
    // R2 R5 R6 R7 word loads, unaligned ones split, tags differ per transfer
    for (int o = 0; o < 4; o++)
      do_req(32'h3000_0300 + 32'(o), 2'd2, 1'b0, 32'h0, 32'hDEAD_BEEF, 32'h0123_4567, 1'b1, 1'b0, o, 1'b0);
    // R2 size code 3 behaves as a word
    do_req(32'h3000_0402, 2'd3, 1'b0, 32'h0, 32'hF0E1_D2C3, 32'hB4A5_9687, 1'b0, 1'b1, 2, 1'b0);
    // R4 R8 stores, upper bytes of store data are garbage and must be ignored
    do_req(32'h4000_0003, 2'd0, 1'b1, 32'hFFFF_FF5A, 32'h0, 32'h0, 1'b1, 1'b1, 1, 1'b0);
    do_req(32'h4000_0013, 2'd1, 1'b1, 32'hBAD0_1234, 32'h0, 32'h0, 1'b0, 1'b1, 0, 1'b0);
    do_req(32'h4000_0021, 2'd2, 1'b1, 32'hCAFE_F00D, 32'h0, 32'h0, 1'b1, 1'b0, 0, 1'b0);
    do_req(32'h4000_0032, 2'd2, 1'b1, 32'h89AB_CDEF, 32'h0, 32'h0, 1'b0, 1'b0, 3, 1'b0);
    do_req(32'h4000_0040, 2'd2, 1'b1, 32'h7654_3210, 32'h0, 32'h0, 1'b1, 1'b1, 0, 1'b0);
    do_req(32'h4000_0051, 2'd1, 1'b1, 32'h9999_ABCD, 32'h0, 32'h0, 1'b0, 1'b0, 0, 1'b0);
    // R10 abort on a split load before the second strobe, then a stray termination while idle
    do_req(32'h5000_0003, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 0, 1'b1);
    bus_ack = 1'b1; bus_rdata = 32'h7777_7777;
    @(negedge clk);
    bus_ack = 1'b0;
    chk(res_valid == 1'b0, "R10 stray termination ignored", {31'h0, res_valid}, 32'h0);
    // R10 abort on a single-transfer load, then normal traffic continues correctly
    do_req(32'h5000_0010, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 0, 1'b1);
    do_req(32'h5000_0022, 2'd2, 1'b0, 32'h0, 32'h1357_9BDF, 32'h2468_ACE0, 1'b0, 1'b1, 1, 1'b0);
    do_req(32'h5000_0033, 2'd1, 1'b0, 32'h0, 32'h0000_00AB, 32'hCD00_0000, 1'b1, 1'b1, 0, 1'b0);

    repeat (5) @(negedge clk);
    chk(bus_q.size() == 0, "R5 missing strobes", 32'(bus_q.size()), 32'h0);
    chk(res_q.size() == 0, "R7 missing results", 32'(res_q.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule